// File: doc/BRIEF.md
# Transceiver Operating Mode Controller

This block turns a requested operating state of a half-duplex radio transceiver into enable signals for the reference oscillator, the frequency synthesizer, the receive chain and the power amplifier. It also supplies the reference and feedback divider values that the synthesizer should use. The requested state and the configuration come from one of two sources. In stand-alone operation the mode comes from two strap pins, and every other setting takes a fixed default. In programmable operation the mode and all settings come from register fields held elsewhere in the chip.

The controller makes the synthesizer wait until the reference oscillator has delivered a set number of valid cycles. This wait happens after every exit from standby. The controller can hold the power amplifier off until the loop reports lock, and it keys the amplifier with the transmit data in amplitude-keyed operation. Modulation type, data polarity and receive gain are each resolved from a pin or a register bit.

All interfaces are plain level signals sampled on `clk`. There is no valid/ready stream and no back-pressure. `ro_tick` is a one-cycle pulse in `clk` time for each valid reference oscillator cycle.

Top module: `trx_mode_ctrl`

## Requirements
- R1: The mode code is 00 standby, 01 receive, 10 transmit and 11 idle. When `prog_mode`=0 the code is {`pin_te`,`pin_re`}. When `prog_mode`=1 it is `reg_opmode`. The code appears on `mode_out` one clock after it is applied.
- R2: One clock after standby is applied, `ro_en`, `pll_en`, `rx_en` and `pa_en` are all 0. The oscillator-cycle count restarts from zero.
- R3: In idle, `ro_en`=1. `pll_en` stays 0 when `reg_idlesel`=0 in programmable operation. When `reg_idlesel`=1, or in stand-alone operation, the synthesizer runs as in any other active mode.
- R4: With the start delay on, `pll_en` rises in the clock after the 8th `ro_tick` counted outside standby. The delay is on when `reg_delpll`=1, and always in stand-alone operation. With it off, `pll_en` rises together with `ro_en`. `pll_en` is never 1 while `ro_en` is 0.
- R5: Receive selects the `reg_rdiv_rx`/`reg_ndiv_rx` pair and transmit selects the `reg_rdiv_tx`/`reg_ndiv_tx` pair. Idle and standby keep the pair of the last receive or transmit state. After reset the receive pair is selected.
- R6: A reference divider below 4 is output as 4, and a feedback divider below 64 is output as 64. In-range values pass unchanged.
- R7: `pa_en` is 1 only in transmit. The amplifier is lock-gated when `reg_pactrl`=0 in programmable operation. In that case it enables from the clock after `pll_lock` is sampled high with the synthesizer running in transmit. That permission then holds until transmit is left. Otherwise it is enabled throughout transmit.
- R8: `mod_fsk` follows `pin_askfsk` (0 ASK, 1 FSK) unless `prog_mode`=1 and `reg_modctrl`=1. In that case it follows `reg_modsel` (0 ASK, 1 FSK).
- R9: The `pin_gain` level is active-low: 0 means high gain. The `reg_lnagain` bit is active-high: 1 means high gain. `lna_high` follows the pin unless `prog_mode`=1 and `reg_lnactrl`=1, in which case it follows the register bit.
- R10: The mark level is `tx_data` XOR `reg_dtapol`. In stand-alone operation the polarity is always normal. In ASK, `pa_en` carries the mark level while the amplifier is permitted. In FSK, `pa_en` stays on and `fsk_hi` equals the mark level during transmit. `fsk_hi` is 0 in ASK.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Controller clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| prog_mode | input | 1 | 0 stand-alone (pins), 1 programmable (registers) |
| pin_re | input | 1 | Mode strap, code bit 0 |
| pin_te | input | 1 | Mode strap, code bit 1 |
| pin_askfsk | input | 1 | Modulation strap, 0 ASK 1 FSK |
| pin_gain | input | 1 | Gain strap, 0 high gain |
| reg_opmode | input | 2 | Programmed mode code |
| reg_idlesel | input | 1 | 1 keeps synthesizer running in idle |
| reg_delpll | input | 1 | 1 enables the oscillator start delay |
| reg_pactrl | input | 1 | 0 lock-gates the amplifier |
| reg_modctrl | input | 1 | 1 takes modulation from `reg_modsel` |
| reg_modsel | input | 1 | Programmed modulation, 0 ASK 1 FSK |
| reg_lnactrl | input | 1 | 1 takes gain from `reg_lnagain` |
| reg_lnagain | input | 1 | Programmed gain, 1 high |
| reg_dtapol | input | 1 | 1 inverts transmit data |
| reg_rdiv_rx | input | 10 | Receive reference divider |
| reg_ndiv_rx | input | 17 | Receive feedback divider |
| reg_rdiv_tx | input | 10 | Transmit reference divider |
| reg_ndiv_tx | input | 17 | Transmit feedback divider |
| ro_tick | input | 1 | One pulse per valid oscillator cycle |
| pll_lock | input | 1 | Lock indication from the synthesizer |
| tx_data | input | 1 | Transmit data bit |
| mode_out | output | 2 | Registered mode code |
| ro_en | output | 1 | Reference oscillator enable |
| pll_en | output | 1 | Synthesizer enable |
| rx_en | output | 1 | Receive chain enable |
| pa_en | output | 1 | Power amplifier enable |
| fsk_hi | output | 1 | Upper-frequency select in FSK |
| mod_fsk | output | 1 | Resolved modulation, 1 FSK |
| lna_high | output | 1 | Resolved receive gain, 1 high |
| rdiv_out | output | 10 | Selected reference divider |
| ndiv_out | output | 17 | Selected feedback divider |

## Verification
The bench targets the start-delay boundary by counting ticks one at a time. A counter off by one would raise the synthesizer after the 7th or 9th tick. A counter not cleared by standby would skip the delay on re-entry. Divider hold is exercised through idle and standby after both receive and transmit. A selection keyed on the live mode would fall back to the receive pair in idle. The lock gate is checked across a receive detour, where a permission that was never cleared would turn the amplifier on without a fresh lock. The pin-versus-register sweeps catch an inverted gain strap, and they catch register bits leaking into stand-alone operation.

// File: rtl/trx_mode_pkg.sv
package trx_mode_pkg;

  typedef enum logic [1:0] {
    MODE_STBY = 2'b00,
    MODE_RX   = 2'b01,
    MODE_TX   = 2'b10,
    MODE_IDLE = 2'b11
  } op_mode_e;

  // Settings after the pin-or-register choice has been made
  typedef struct packed {
    logic idle_full;   // synthesizer stays on in idle
    logic pll_delay;   // wait for oscillator cycles before synthesizer
    logic pa_always;   // amplifier on for all of transmit
    logic use_fsk;     // 1 FSK, 0 ASK
    logic lna_high;    // 1 high receive gain
    logic inv_data;    // invert transmit data
  } eff_cfg_t;

endpackage

// File: rtl/trx_mode_src.sv
module trx_mode_src
  import trx_mode_pkg::*;
(
  input  logic       prog_mode,
  input  logic       pin_re,
  input  logic       pin_te,
  input  logic       pin_askfsk,
  input  logic       pin_gain,
  input  logic [1:0] reg_opmode,
  input  logic       reg_idlesel,
  input  logic       reg_delpll,
  input  logic       reg_pactrl,
  input  logic       reg_modctrl,
  input  logic       reg_modsel,
  input  logic       reg_lnactrl,
  input  logic       reg_lnagain,
  input  logic       reg_dtapol,
  output op_mode_e   mode_req,
  output eff_cfg_t   cfg
);

  logic mod_from_reg;
  logic lna_from_reg;

  assign mod_from_reg = prog_mode & reg_modctrl;
  assign lna_from_reg = prog_mode & reg_lnactrl;

  always_comb begin
    if (prog_mode) mode_req = op_mode_e'(reg_opmode);
    else           mode_req = op_mode_e'({pin_te, pin_re});
  end

  always_comb begin
    // stand-alone operation runs on fixed defaults
    cfg.idle_full = prog_mode ? reg_idlesel : 1'b1;
    cfg.pll_delay = prog_mode ? reg_delpll  : 1'b1;
    cfg.pa_always = prog_mode ? reg_pactrl  : 1'b1;
    cfg.inv_data  = prog_mode ? reg_dtapol  : 1'b0;
    cfg.use_fsk   = mod_from_reg ? reg_modsel  : pin_askfsk;
    cfg.lna_high  = lna_from_reg ? reg_lnagain : ~pin_gain;
  end

endmodule

// File: rtl/trx_start_timer.sv
module trx_start_timer #(
  parameter int START_CYCLES = 8
) (
  input  logic clk,
  input  logic rst_n,
  input  logic active,
  input  logic ro_tick,
  output logic done
);

  localparam int CNT_W = $clog2(START_CYCLES + 1);
  localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(START_CYCLES);

  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
    end else if (!active) begin
      cnt_q <= '0;
    end else if (ro_tick && (cnt_q != CNT_LAST)) begin
      cnt_q <= cnt_q + 1'b1;
    end
  end

  assign done = (cnt_q == CNT_LAST);

endmodule

// File: rtl/trx_div_pair.sv
module trx_div_pair #(
  parameter int W   = 10,
  parameter int MIN = 4
) (
  input  logic [W-1:0] rx_val,
  input  logic [W-1:0] tx_val,
  input  logic         sel_tx,
  output logic [W-1:0] div_out
);

  localparam logic [W-1:0] FLOOR = W'(MIN);

  logic [W-1:0] picked;

  assign picked  = sel_tx ? tx_val : rx_val;
  assign div_out = (picked < FLOOR) ? FLOOR : picked;

endmodule

// File: rtl/trx_pa_gate.sv
module trx_pa_gate (
  input  logic clk,
  input  logic rst_n,
  input  logic in_tx,
  input  logic pll_en,
  input  logic pll_lock,
  input  logic pa_always,
  input  logic use_fsk,
  input  logic mark,
  output logic pa_en,
  output logic fsk_hi
);

  logic lock_seen_q;
  logic pa_allowed;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      lock_seen_q <= 1'b0;
    end else if (!in_tx) begin
      lock_seen_q <= 1'b0;
    end else if (pll_en && pll_lock) begin
      lock_seen_q <= 1'b1;
    end
  end

  assign pa_allowed = in_tx & (pa_always | lock_seen_q);
  // ASK keys the amplifier; FSK keeps it on and steers frequency
  assign pa_en  = pa_allowed & (use_fsk | mark);
  assign fsk_hi = in_tx & use_fsk & mark;

endmodule

// File: rtl/trx_mode_ctrl.sv
module trx_mode_ctrl
  import trx_mode_pkg::*;
#(
  parameter int RDIV_W       = 10,
  parameter int NDIV_W       = 17,
  parameter int RDIV_MIN     = 4,
  parameter int NDIV_MIN     = 64,
  parameter int START_CYCLES = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              prog_mode,
  input  logic              pin_re,
  input  logic              pin_te,
  input  logic              pin_askfsk,
  input  logic              pin_gain,
  input  logic [1:0]        reg_opmode,
  input  logic              reg_idlesel,
  input  logic              reg_delpll,
  input  logic              reg_pactrl,
  input  logic              reg_modctrl,
  input  logic              reg_modsel,
  input  logic              reg_lnactrl,
  input  logic              reg_lnagain,
  input  logic              reg_dtapol,
  input  logic [RDIV_W-1:0] reg_rdiv_rx,
  input  logic [NDIV_W-1:0] reg_ndiv_rx,
  input  logic [RDIV_W-1:0] reg_rdiv_tx,
  input  logic [NDIV_W-1:0] reg_ndiv_tx,
  input  logic              ro_tick,
  input  logic              pll_lock,
  input  logic              tx_data,
  output logic [1:0]        mode_out,
  output logic              ro_en,
  output logic              pll_en,
  output logic              rx_en,
  output logic              pa_en,
  output logic              fsk_hi,
  output logic              mod_fsk,
  output logic              lna_high,
  output logic [RDIV_W-1:0] rdiv_out,
  output logic [NDIV_W-1:0] ndiv_out
);

  op_mode_e mode_req;
  op_mode_e mode_q;
  eff_cfg_t cfg;
  logic     sel_tx_q;
  logic     timer_done;
  logic     pll_req;
  logic     mark;

  trx_mode_src u_src (
    .prog_mode   (prog_mode),
    .pin_re      (pin_re),
    .pin_te      (pin_te),
    .pin_askfsk  (pin_askfsk),
    .pin_gain    (pin_gain),
    .reg_opmode  (reg_opmode),
    .reg_idlesel (reg_idlesel),
    .reg_delpll  (reg_delpll),
    .reg_pactrl  (reg_pactrl),
    .reg_modctrl (reg_modctrl),
    .reg_modsel  (reg_modsel),
    .reg_lnactrl (reg_lnactrl),
    .reg_lnagain (reg_lnagain),
    .reg_dtapol  (reg_dtapol),
    .mode_req    (mode_req),
    .cfg         (cfg)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mode_q   <= MODE_STBY;
      sel_tx_q <= 1'b0;
    end else begin
      mode_q <= mode_req;
      // idle and standby keep the last active pair
      if (mode_req == MODE_RX)      sel_tx_q <= 1'b0;
      else if (mode_req == MODE_TX) sel_tx_q <= 1'b1;
    end
  end

  trx_start_timer #(.START_CYCLES(START_CYCLES)) u_timer (
    .clk     (clk),
    .rst_n   (rst_n),
    .active  (ro_en),
    .ro_tick (ro_tick),
    .done    (timer_done)
  );

  assign ro_en   = (mode_q != MODE_STBY);
  assign pll_req = (mode_q == MODE_RX) | (mode_q == MODE_TX) |
                   ((mode_q == MODE_IDLE) & cfg.idle_full);
  assign pll_en  = pll_req & (~cfg.pll_delay | timer_done);
  assign rx_en   = (mode_q == MODE_RX) & pll_en;
  assign mark    = tx_data ^ cfg.inv_data;

  trx_pa_gate u_pa (
    .clk       (clk),
    .rst_n     (rst_n),
    .in_tx     (mode_q == MODE_TX),
    .pll_en    (pll_en),
    .pll_lock  (pll_lock),
    .pa_always (cfg.pa_always),
    .use_fsk   (cfg.use_fsk),
    .mark      (mark),
    .pa_en     (pa_en),
    .fsk_hi    (fsk_hi)
  );

  generate
    for (genvar g = 0; g < 2; g++) begin : g_div
      if (g == 0) begin : g_ref
        trx_div_pair #(.W(RDIV_W), .MIN(RDIV_MIN)) u_pair (
          .rx_val  (reg_rdiv_rx),
          .tx_val  (reg_rdiv_tx),
          .sel_tx  (sel_tx_q),
          .div_out (rdiv_out)
        );
      end else begin : g_fb
        trx_div_pair #(.W(NDIV_W), .MIN(NDIV_MIN)) u_pair (
          .rx_val  (reg_ndiv_rx),
          .tx_val  (reg_ndiv_tx),
          .sel_tx  (sel_tx_q),
          .div_out (ndiv_out)
        );
      end
    end
  endgenerate

  assign mode_out = mode_q;
  assign mod_fsk  = cfg.use_fsk;
  assign lna_high = cfg.lna_high;

endmodule

// File: rtl/trx_mode_ctrl_chk.sv
module trx_mode_ctrl_chk #(
  parameter int RDIV_W   = 10,
  parameter int NDIV_W   = 17,
  parameter int RDIV_MIN = 4,
  parameter int NDIV_MIN = 64
) (
  input logic              clk,
  input logic              rst_n,
  input logic              prog_mode,
  input logic              reg_idlesel,
  input logic              reg_delpll,
  input logic [RDIV_W-1:0] reg_rdiv_rx,
  input logic [1:0]        mode_out,
  input logic              ro_en,
  input logic              pll_en,
  input logic              rx_en,
  input logic              pa_en,
  input logic [RDIV_W-1:0] rdiv_out,
  input logic [NDIV_W-1:0] ndiv_out
);

  a_r2_standby_all_off: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_out == 2'b00) |-> !(ro_en || pll_en || rx_en || pa_en));

  a_r3_shallow_idle: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_out == 2'b11 && prog_mode && !reg_idlesel) |-> (ro_en && !pll_en));

  a_r4_pll_needs_ro: assert property (@(posedge clk) disable iff (!rst_n)
    pll_en |-> ro_en);

  a_r4_delay_on_entry: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(mode_out) == 2'b00 && mode_out != 2'b00 && (!prog_mode || reg_delpll))
      |-> !pll_en);

  a_r5_rx_pair: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_out == 2'b01 && reg_rdiv_rx >= RDIV_W'(RDIV_MIN)) |-> (rdiv_out == reg_rdiv_rx));

  a_r6_floor: assert property (@(posedge clk) disable iff (!rst_n)
    (rdiv_out >= RDIV_W'(RDIV_MIN)) && (ndiv_out >= NDIV_W'(NDIV_MIN)));

  a_r7_pa_tx_only: assert property (@(posedge clk) disable iff (!rst_n)
    pa_en |-> (mode_out == 2'b10));

endmodule

bind trx_mode_ctrl trx_mode_ctrl_chk #(
  .RDIV_W(RDIV_W), .NDIV_W(NDIV_W), .RDIV_MIN(RDIV_MIN), .NDIV_MIN(NDIV_MIN)
) u_chk (
  .clk(clk), .rst_n(rst_n), .prog_mode(prog_mode), .reg_idlesel(reg_idlesel),
  .reg_delpll(reg_delpll), .reg_rdiv_rx(reg_rdiv_rx), .mode_out(mode_out),
  .ro_en(ro_en), .pll_en(pll_en), .rx_en(rx_en), .pa_en(pa_en),
  .rdiv_out(rdiv_out), .ndiv_out(ndiv_out)
);

// File: tb/trx_mode_ctrl_tb.sv
module trx_mode_ctrl_tb;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        prog_mode, pin_re, pin_te, pin_askfsk, pin_gain;
  logic [1:0]  reg_opmode;
  logic        reg_idlesel, reg_delpll, reg_pactrl, reg_modctrl, reg_modsel;
  logic        reg_lnactrl, reg_lnagain, reg_dtapol;
  logic [9:0]  reg_rdiv_rx, reg_rdiv_tx;
  logic [16:0] reg_ndiv_rx, reg_ndiv_tx;
  logic        ro_tick, pll_lock, tx_data;
  logic [1:0]  mode_out;
  logic        ro_en, pll_en, rx_en, pa_en, fsk_hi, mod_fsk, lna_high;
  logic [9:0]  rdiv_out;
  logic [16:0] ndiv_out;

  int vectors = 0;
  int fails   = 0;

  always #5 clk = ~clk;

  trx_mode_ctrl u_dut (.*);

  task automatic chk(string req, int act, int exp);
    vectors++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic step();
    @(posedge clk);
    #1;
  endtask

  task automatic ticks(int n);
    for (int i = 0; i < n; i++) begin
      ro_tick = 1'b1;
      step();
      ro_tick = 1'b0;
    end
  endtask

  function automatic int floor_of(int v, int m);
    return (v < m) ? m : v;
  endfunction

  initial begin
    #2_000_000;
    fails++;
    $display("FAIL watchdog actual=running expected=finished");
    $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  end

  initial begin
    int exp_tx;
    int seq[8];
    rst_n = 1'b0;
    prog_mode = 0; pin_re = 0; pin_te = 0; pin_askfsk = 1; pin_gain = 0;
    reg_opmode = 0; reg_idlesel = 1; reg_delpll = 1; reg_pactrl = 1;
    reg_modctrl = 0; reg_modsel = 1; reg_lnactrl = 0; reg_lnagain = 0; reg_dtapol = 0;
    reg_rdiv_rx = 20; reg_ndiv_rx = 1000; reg_rdiv_tx = 30; reg_ndiv_tx = 2000;
    ro_tick = 0; pll_lock = 0; tx_data = 0;
    repeat (3) step();
    rst_n = 1'b1;
    #1;
    // reset state
    chk("R1 reset mode", mode_out, 0);
    chk("R2 reset enables", {ro_en, pll_en, rx_en, pa_en}, 0);
    chk("R5 reset pair", rdiv_out, 20);

    // R1 and R2: decode sweep over both sources
    for (int src = 0; src < 2; src++) begin
      for (int code = 0; code < 4; code++) begin
        prog_mode = src[0];
        reg_opmode = src[0] ? code[1:0] : 2'b00;
        {pin_te, pin_re} = src[0] ? 2'b00 : code[1:0];
        step();
        chk("R1 mode decode", mode_out, code);
        chk("R2 oscillator enable", ro_en, (code != 0) ? 1 : 0);
      end
    end

    // R4: start delay boundary in programmable operation
    prog_mode = 1; {pin_te, pin_re} = 0;
    reg_opmode = 0; step();
    reg_opmode = 1; step();
    chk("R4 no pll before ticks", pll_en, 0);
    for (int k = 1; k <= 8; k++) begin
      ticks(1);
      chk("R4 pll after tick count", pll_en, (k == 8) ? 1 : 0);
    end
    chk("R4 rx chain on", rx_en, 1);
    // R2: standby drops all and restarts the count
    reg_opmode = 0; step();
    chk("R2 standby all off", {ro_en, pll_en, rx_en, pa_en}, 0);
    reg_opmode = 1; step();
    chk("R2 count restarted", pll_en, 0);
    ticks(7);
    chk("R2 seven ticks not enough", pll_en, 0);
    reg_opmode = 0; step();
    // R4: delay off
    reg_delpll = 0;
    reg_opmode = 1; step();
    chk("R4 undelayed start", {ro_en, pll_en}, 3);

    // R3: idle depth
    reg_opmode = 3; reg_idlesel = 0; step();
    chk("R3 shallow idle", {ro_en, pll_en}, 2);
    reg_idlesel = 1; step();
    chk("R3 full idle", {ro_en, pll_en}, 3);
    reg_opmode = 0; step();
    prog_mode = 0; {pin_te, pin_re} = 2'b11; reg_idlesel = 0; reg_delpll = 0; step();
    chk("R3 stand-alone idle delayed", {ro_en, pll_en}, 2);
    ticks(8);
    chk("R4 stand-alone idle after delay", pll_en, 1);

    // R5: divider hold through idle and standby
    prog_mode = 1; {pin_te, pin_re} = 0; reg_delpll = 0; reg_idlesel = 1;
    seq = '{1, 2, 3, 0, 1, 3, 0, 2};
    exp_tx = 0;
    foreach (seq[i]) begin
      reg_opmode = seq[i][1:0];
      step();
      if (seq[i] == 1) exp_tx = 0;
      if (seq[i] == 2) exp_tx = 1;
      chk("R5 reference pick", rdiv_out, exp_tx ? 30 : 20);
      chk("R5 feedback pick", ndiv_out, exp_tx ? 2000 : 1000);
    end

    // R6: floors
    reg_opmode = 1; step();
    for (int v = 0; v < 8; v++) begin
      reg_rdiv_rx = 10'(v); #1;
      chk("R6 reference floor", rdiv_out, floor_of(v, 4));
    end
    for (int v = 60; v < 68; v++) begin
      reg_ndiv_rx = 17'(v); #1;
      chk("R6 feedback floor", ndiv_out, floor_of(v, 64));
    end
    reg_rdiv_rx = 20; reg_ndiv_rx = 1000;

    // R7: lock gating
    reg_modctrl = 1; reg_modsel = 1; reg_pactrl = 0; pll_lock = 0;
    reg_opmode = 2; step();
    chk("R7 gated before lock", pa_en, 0);
    step();
    chk("R7 still gated", pa_en, 0);
    pll_lock = 1; step();
    chk("R7 on after lock", pa_en, 1);
    pll_lock = 0; step();
    chk("R7 permission held", pa_en, 1);
    reg_opmode = 1; step();
    chk("R7 off in receive", pa_en, 0);
    reg_opmode = 2; step();
    chk("R7 relock needed", pa_en, 0);
    reg_pactrl = 1; #1;
    chk("R7 always-on transmit", pa_en, 1);

    // R8, R9: source sweeps
    for (int p = 0; p < 2; p++)
      for (int c = 0; c < 2; c++)
        for (int pin = 0; pin < 2; pin++)
          for (int b = 0; b < 2; b++) begin
            prog_mode = p[0];
            reg_modctrl = c[0]; reg_lnactrl = c[0];
            pin_askfsk = pin[0]; pin_gain = pin[0];
            reg_modsel = b[0]; reg_lnagain = b[0];
            #1;
            chk("R8 modulation source", mod_fsk, (p == 1 && c == 1) ? b : pin);
            chk("R9 gain source", lna_high, (p == 1 && c == 1) ? b : 1 - pin);
          end

    // R10: polarity and keying in transmit
    {pin_te, pin_re} = 2'b10; reg_opmode = 2; reg_pactrl = 1; reg_modctrl = 1;
    for (int p = 0; p < 2; p++)
      for (int f = 0; f < 2; f++)
        for (int pol = 0; pol < 2; pol++)
          for (int d = 0; d < 2; d++) begin
            int mk;
            prog_mode = p[0];
            reg_modsel = f[0]; pin_askfsk = f[0];
            reg_dtapol = pol[0]; tx_data = d[0];
            step();
            mk = (p == 1) ? (d ^ pol) : d;
            chk("R10 amplifier keying", pa_en, (f == 1) ? 1 : mk);
            chk("R10 frequency select", fsk_hi, (f == 1) ? mk : 0);
          end

    $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  end

endmodule